// File: doc/BRIEF.md
# Two-Channel PWM Capture Timer

This block has a 16-bit up-counter and two capture channels. It measures the period and the high time of an external pulse-width-modulated signal. Each channel takes its trigger from one of two places: its own input pin, or the input pin of the other channel. A polarity bit chooses whether the channel reacts to the rising or the falling edge of that source. On a capture, the channel copies the counter into its capture register. It also sets a status flag and, when enabled, raises its interrupt line.

The input pins are asynchronous. Each pin passes through a two-stage synchroniser, and the edges are found one clock after that. A restart mode sets the counter to zero on every channel-0 capture. To measure a PWM signal, feed it to pin 0, set channel 0 to capture rising edges of pin 0, and set channel 1 to capture falling edges of pin 0. Channel 0 then holds the period and channel 1 holds the high time.

Software uses a small register port. Writes are synchronous and reads are combinational. Software can also raise a channel event with no input edge.

Top module: `pwm_capture_timer`

## Requirements
- R1: A pin change that is present at clock edge k is captured at edge k+2. At that edge the channel's capture register takes the counter value held just before the edge, and the capture flag becomes 1.
- R2: If a capture occurs while the channel's capture flag is 1 and is not being cleared in the same cycle, the channel's overcapture flag becomes 1.
- R3: Output irq[n] is high exactly when channel n's capture flag is 1 and its interrupt enable bit is 1.
- R4: Writing 1 to bit n of the event register (address 2) sets capture flag n without an input edge. The capture registers are left unchanged. The event register reads as 0.
- R5: Each channel has a 2-bit source field: control bits [3:2] for channel 0 and [6:5] for channel 1. Value 01 selects the channel's own pin, value 10 selects the other channel's pin, and values 00 and 11 disable capture.
- R6: The polarity bit is control bit 4 for channel 0 and bit 7 for channel 1. Value 0 captures rising edges and value 1 captures falling edges.
- R7: When restart mode (control bit 1) is on, a channel-0 capture sets the counter to 0. With channel 0 on the rising edge of pin 0 and channel 1 on the falling edge of pin 0, the results are in clock cycles: CAP0 = period − 1 and CAP1 = high time − 1.
- R8: The status register is at address 1: bit 0 is flag0, bit 1 is flag1, bit 2 is overcapture0 and bit 3 is overcapture1. Writing 1 to a bit clears it. A capture in the same cycle as a clear leaves the flag at 1.
- R9: Control bit 0 enables counting. The 16-bit counter wraps from 0xFFFF to 0. Writing address 5 loads the counter, and this load has priority over restart and over counting.
- R10: After reset, every readable register is 0 and irq is 0. The readable registers are control (address 0, interrupt enables at bits 8 and 9), status (1), event (2), CAP0 (3), CAP1 (4) and counter (5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 2 | Asynchronous capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The bench checks the exact capture latency by loading a known counter value and then raising a pin. A design with one synchroniser stage more or less would latch a neighbouring count. A status clear is placed on the same edge as a capture. A design that let the clear win would lose the event, and one that took the pre-clear flag into account would report a false overcapture. The bench measures PWM signals with two different duty cycles in restart mode and checks the exact period − 1 and high time − 1 values. This exposes an off-by-one in the restart or in the edge selection. The bench also checks disabled sources, the wrong polarity, software events and counter wrap. A design that routes the sources wrongly or ignores the polarity bit would set flags it should not.

// File: rtl/pwm_capture_timer.sv
`timescale 1ns/1ps
module pwm_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cap_pin,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [1:0]       irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_EVT = 3'd2,
                         A_CAP0 = 3'd3, A_CAP1 = 3'd4, A_CNT  = 3'd5;
  localparam int CTRL_W = 10;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, cap0_q, cap1_q;
  logic [1:0] pin_sync, pin_prev, rise, fall;
  logic [1:0] cap_evt, gen_evt, clr_flag, clr_over, flag_q, over_q, ie;
  logic run, restart_en, cnt_wr;

  for (genvar p = 0; p < 2; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], cap_pin[p]};
    assign pin_sync[p] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_prev <= '0;
    else        pin_prev <= pin_sync;

  assign rise = pin_sync & ~pin_prev;
  assign fall = ~pin_sync & pin_prev;

  assign run        = ctrl_q[0];
  assign restart_en = ctrl_q[1];
  assign ie         = ctrl_q[9:8];
  assign cnt_wr     = wr_en && wr_addr == A_CNT;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam int OTH = 1 - ch;
    logic [1:0] src;
    logic       pol, sel_r, sel_f;
    assign src = ctrl_q[2+3*ch +: 2];
    assign pol = ctrl_q[4+3*ch];
    always_comb begin
      case (src)
        2'b01:   begin sel_r = rise[ch];  sel_f = fall[ch];  end
        2'b10:   begin sel_r = rise[OTH]; sel_f = fall[OTH]; end
        default: begin sel_r = 1'b0;      sel_f = 1'b0;      end
      endcase
    end
    assign cap_evt[ch]  = pol ? sel_f : sel_r;
    assign gen_evt[ch]  = wr_en && wr_addr == A_EVT  && wr_data[ch];
    assign clr_flag[ch] = wr_en && wr_addr == A_STAT && wr_data[ch];
    assign clr_over[ch] = wr_en && wr_addr == A_STAT && wr_data[2+ch];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL)   ctrl_q <= wr_data[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_q <= '0;
      over_q <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        flag_q[c] <= (flag_q[c] & ~clr_flag[c]) | cap_evt[c] | gen_evt[c];
        over_q[c] <= (over_q[c] & ~clr_over[c]) |
                     (cap_evt[c] & flag_q[c] & ~clr_flag[c]);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap0_q <= '0;
      cap1_q <= '0;
    end else begin
      if (cap_evt[0]) cap0_q <= cnt_q;
      if (cap_evt[1]) cap1_q <= cnt_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         cnt_q <= '0;
    else if (cnt_wr)                    cnt_q <= wr_data;
    else if (restart_en && cap_evt[0])  cnt_q <= '0;
    else if (run)                       cnt_q <= cnt_q + 1'b1;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      A_STAT:  rd_data[3:0] = {over_q, flag_q};
      A_CAP0:  rd_data = cap0_q;
      A_CAP1:  rd_data = cap1_q;
      A_CNT:   rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end

  assign irq = flag_q & ie;
endmodule

// File: rtl/pwm_capture_timer_chk.sv
`timescale 1ns/1ps
module pwm_capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cap_evt,
  input logic [1:0]       clr_flag,
  input logic [1:0]       flag_q,
  input logic [1:0]       over_q,
  input logic [1:0]       ie,
  input logic [1:0]       irq,
  input logic             run,
  input logic             restart_en,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap0_q,
  input logic [CNT_W-1:0] cap1_q
);
  AST_CAP0_LATCH: assert property (@(posedge clk) disable iff (!rst_n) cap_evt[0] |=> cap0_q == $past(cnt_q)); // R1
  AST_CAP1_LATCH: assert property (@(posedge clk) disable iff (!rst_n) cap_evt[1] |=> cap1_q == $past(cnt_q)); // R1
  AST_CAP0_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cap_evt[0] |=> $stable(cap0_q)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) cap_evt[0] |=> flag_q[0]); // R8
  AST_OVER0_SET: assert property (@(posedge clk) disable iff (!rst_n) cap_evt[0] && flag_q[0] && !clr_flag[0] |=> over_q[0]); // R2
  AST_OVER1_SET: assert property (@(posedge clk) disable iff (!rst_n) cap_evt[1] && flag_q[1] && !clr_flag[1] |=> over_q[1]); // R2
  AST_IRQ0_GATED: assert property (@(posedge clk) disable iff (!rst_n) !ie[0] |-> !irq[0]); // R3
  AST_IRQ1_GATED: assert property (@(posedge clk) disable iff (!rst_n) !ie[1] |-> !irq[1]); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) restart_en && cap_evt[0] && !cnt_wr |=> cnt_q == '0); // R7
  AST_COUNTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cnt_wr && !(restart_en && cap_evt[0]) && cnt_q == '1 |=> cnt_q == '0); // R9
endmodule

bind pwm_capture_timer pwm_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .clr_flag(clr_flag),
  .flag_q(flag_q), .over_q(over_q), .ie(ie), .irq(irq), .run(run),
  .restart_en(restart_en), .cnt_wr(cnt_wr), .cnt_q(cnt_q),
  .cap0_q(cap0_q), .cap1_q(cap1_q)
);

// File: tb/tb_pwm_capture_timer.sv
`timescale 1ns/1ps
module tb_pwm_capture_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cap_pin = 2'b00;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0] irq;
  int n_chk = 0, n_bad = 0;
  logic [15:0] v, keep0, keep1;

  always #10 clk = ~clk;

  pwm_capture_timer dut (.clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R10", $sformatf("reg %0d after reset", a), v, 16'h0);
    end
    check("R10", "irq after reset", {14'd0, irq}, 16'h0);
  endtask

  task automatic t_latency();
    wr(0, 16'h0005);
    wr(1, 16'h000F);
    wr(5, 16'd100);
    cap_pin[0] = 1'b1;
    idle(2);
    rd(1, v); check("R1", "flag0 before capture edge", v & 16'h1, 16'h0);
    idle(1);
    rd(1, v); check("R1", "flag0 at capture edge", v & 16'h1, 16'h1);
    rd(3, v); check("R1", "CAP0 latency value", v, 16'd102);
  endtask

  task automatic t_clear_race();
    wr(1, 16'h0004);
    cap_pin[0] = 1'b0; idle(3);
    cap_pin[0] = 1'b1; idle(2);
    wr(1, 16'h0001);
    rd(1, v); check("R8", "capture beats clear, no overcapture", v, 16'h0001);
    cap_pin[0] = 1'b0; idle(3);
    cap_pin[0] = 1'b1; idle(4);
    rd(1, v); check("R2", "overcapture on uncleared flag", v, 16'h0005);
    wr(1, 16'h000F);
    rd(1, v); check("R8", "write-one clear", v, 16'h0000);
  endtask

  task automatic t_generate();
    rd(3, keep0); rd(4, keep1);
    wr(0, 16'h0205);
    wr(2, 16'h0003);
    rd(1, v); check("R4", "event flags set", v, 16'h0003);
    check("R3", "irq only where enabled", {14'd0, irq}, 16'h0002);
    rd(3, v); check("R4", "CAP0 untouched", v, keep0);
    rd(4, v); check("R4", "CAP1 untouched", v, keep1);
    rd(2, v); check("R4", "event reg reads 0", v, 16'h0);
    wr(0, 16'h0305);
    check("R3", "irq both enabled", {14'd0, irq}, 16'h0003);
    wr(1, 16'h0003);
    check("R3", "irq gone after clear", {14'd0, irq}, 16'h0000);
  endtask

  task automatic t_source();
    cap_pin = 2'b00; idle(3);
    wr(0, 16'h00A1);
    wr(1, 16'h000F);
    cap_pin[0] = 1'b1; idle(4); cap_pin[0] = 1'b0; idle(4);
    rd(1, v); check("R5", "pin0 ignored with ch0 off and ch1 own", v, 16'h0);
    cap_pin[1] = 1'b1; idle(4);
    rd(1, v); check("R6", "rising ignored with falling polarity", v, 16'h0);
    cap_pin[1] = 1'b0; idle(4);
    rd(1, v); check("R6", "falling captured on own pin", v, 16'h0002);
    wr(0, 16'h000D);
    wr(1, 16'h000F);
    cap_pin[0] = 1'b1; idle(4); cap_pin[0] = 1'b0; idle(4);
    rd(1, v); check("R5", "source 11 disables capture", v, 16'h0);
  endtask

  task automatic t_pwm(input int hi, input int lo, input logic [15:0] exp_stat);
    cap_pin = 2'b00; idle(4);
    wr(0, 16'h00C7);
    wr(1, 16'h000F);
    cap_pin[0] = 1'b1; idle(hi);
    cap_pin[0] = 1'b0; idle(lo);
    cap_pin[0] = 1'b1; idle(5);
    rd(3, v); check("R7", $sformatf("period %0d+%0d", hi, lo), v, 16'(hi + lo - 1));
    rd(4, v); check("R7", $sformatf("high time %0d", hi), v, 16'(hi - 1));
    rd(1, v); check("R2", "status after pwm", v, exp_stat);
    check("R3", "no irq without enables", {14'd0, irq}, 16'h0);
  endtask

  task automatic t_wrap();
    wr(0, 16'h0001);
    wr(5, 16'hFFFE);
    rd(5, v); check("R9", "counter load", v, 16'hFFFE);
    idle(2);
    rd(5, v); check("R9", "counter wrap", v, 16'h0000);
    wr(0, 16'h0000);
    rd(5, keep0); idle(5);
    rd(5, v); check("R9", "counter holds when stopped", v, keep0);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_latency();
    t_clear_race();
    t_generate();
    t_source();
    t_pwm(37, 63, 16'h0007);
    t_pwm(10, 5, 16'h0007);
    t_wrap();
    summary();
  end
endmodule